// File: doc/BRIEF.md
# Fixed-Vector Interrupt Request Unit

This block gathers interrupt requests from five sources: two active-low external pins, two timer overflow events and one serial event. It keeps a request flag for each source. It masks the flags with a per-source enable and a global enable, and picks one pending source in a fixed order. It then offers the fetch unit a request together with a fixed 16-bit vector address. Vector slots start at 0x0003 and are 8 bytes apart.

The request output and the vector form a valid/ready pair. `irq_req` is the valid signal and `irq_ack` is the ready signal. Once `irq_req` is high, it and `irq_vec` stay unchanged until the core acknowledges. An acknowledge is taken only in a cycle where `irq_req` is high. When an acknowledge is taken, the unit clears the flag of the chosen source if the hardware owns that flag. Timer flags are always cleared. External flags are cleared only in edge mode. The serial flag is never cleared, because it is the OR of two flags that software owns. After an acknowledge the unit stays silent until the core pulses `irq_reti` to show that the handler has returned.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, `irq_req` is 0 and `irq_vec` is 0x0000. Whenever `irq_req` is 0, `irq_vec` reads 0x0000.
- R2: When `irq_req` is high, `irq_vec` holds the slot of the chosen source. The slots are: external 0 at 0x0003, timer 0 at 0x000B, external 1 at 0x0013, timer 1 at 0x001B and serial at 0x0023.
- R3: When several enabled sources are pending, the one chosen is the first in this order: external 0, timer 0, external 1, timer 1, serial.
- R4: In edge mode (`ext_edge_mode[k]`=1), a high-to-low transition on `ext_irq_n[k]`, seen after two-flop synchronization, sets a flag. The flag stays set after the pin returns high and is cleared when that source is acknowledged.
- R5: In level mode (`ext_edge_mode[k]`=0), the external request follows the inverted synchronized pin. An acknowledge does not clear it, so a pin that is still low requests again after return. A pin that is high raises nothing.
- R6: A pulse on `tmr_ovf[k]` sets a timer flag, and the acknowledge of that source clears it.
- R7: The serial request is `ser_tx_done` OR `ser_rx_done`. An acknowledge never clears it, so while either input stays high the serial request is raised again after each return.
- R8: `src_en` bits, indexed 0 to 4 in the R3 order, mask pending sources. A masked source raises nothing, keeps its flag, and is requested once it is enabled.
- R9: While `glb_en` is 0, no new request is raised.
- R10: After an accepted acknowledge, `irq_req` stays 0 until an `irq_reti` pulse arrives, even if requests are pending.
- R11: While `irq_req` is high and `irq_ack` is 0, the next cycle still has `irq_req` high with `irq_vec` unchanged, even if a source earlier in the order becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq_n | input | 2 | External request pins, active low, asynchronous |
| ext_edge_mode | input | 2 | 1 selects edge mode and 0 selects level mode, one bit per external pin |
| tmr_ovf | input | 2 | Timer overflow pulses, one per timer |
| ser_tx_done | input | 1 | Serial transmit-done flag, owned by software |
| ser_rx_done | input | 1 | Serial receive-done flag, owned by software |
| src_en | input | 5 | Per-source enables in R3 order |
| glb_en | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Acknowledge from the core (ready) |
| irq_reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request (valid) |
| irq_vec | output | 16 | Vector address of the chosen source |

## Verification
The checker relies on the core pulsing `irq_reti` only while no request is outstanding and never in the same cycle as an acknowledge. It also relies on the core treating `irq_ack` as meaningful only while `irq_req` is high. The directed tasks drive every acknowledge only after they have seen `irq_req` high. They issue `irq_reti` several cycles after the acknowledge, once the serial flags or level pins have been set up for the case under test. All inputs change on the falling clock edge, so the external pins always pass through the synchronizer with a clean, single transition.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int SRC_W   = $clog2(NUM_SRC);

  typedef enum logic [SRC_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } irq_src_e;
endpackage

// File: rtl/irq_ext_flag.sv
// One external request: synchronizer, falling-edge detector, sticky flag or level follow.
module irq_ext_flag #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic flag
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   sticky_q;
  logic                   pin_s;
  logic                   fall;

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = last_q & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      last_q <= pin_s;
    end
  end

  // A new edge wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sticky_q <= 1'b0;
    else if (!edge_mode) sticky_q <= 1'b0;
    else if (fall)       sticky_q <= 1'b1;
    else if (clr)        sticky_q <= 1'b0;
  end

  assign flag = edge_mode ? sticky_q : ~pin_s;
endmodule

// File: rtl/irq_sticky_flag.sv
// Set-by-pulse, clear-on-acknowledge flag for the timer overflow sources.
module irq_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/irq_arbiter.sv
// Fixed-order selection: the lowest index wins.
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]     pending,
  output logic             any,
  output logic [SRC_W-1:0] sel
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending[i]) begin
        any = 1'b1;
        sel = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_service_ctl.sv
// Request/acknowledge/return sequencing; the chosen source is frozen while the request is up.
module irq_service_ctl
  import irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any,
  input  logic [SRC_W-1:0] sel,
  input  logic             glb_en,
  input  logic             ack,
  input  logic             reti,
  output logic             req,
  output logic [SRC_W-1:0] cur,
  output logic [N-1:0]     clr_onehot
);
  logic busy_q;
  logic take;

  assign take = req & ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req    <= 1'b0;
      cur    <= '0;
      busy_q <= 1'b0;
    end else begin
      if (req) begin
        if (ack) begin
          req    <= 1'b0;
          busy_q <= 1'b1;
        end
      end else begin
        if (reti) busy_q <= 1'b0;
        else if (!busy_q && glb_en && any) begin
          req <= 1'b1;
          cur <= sel;
        end
      end
    end
  end

  always_comb begin
    clr_onehot = '0;
    if (take) clr_onehot[cur] = 1'b1;
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
#(
  parameter int          VEC_W       = 16,
  parameter int          VEC_BASE    = 3,
  parameter int          VEC_STRIDE  = 8,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ext_irq_n,
  input  logic [1:0]       ext_edge_mode,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_tx_done,
  input  logic             ser_rx_done,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic             glb_en,
  input  logic             irq_ack,
  input  logic             irq_reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int NUM_PAIR = 2;

  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] clr_onehot;
  logic               any;
  logic [SRC_W-1:0]   sel;
  logic [SRC_W-1:0]   cur;

  // External k sits at index 2k, timer k at index 2k+1.
  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    irq_ext_flag #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (ext_irq_n[k]),
      .edge_mode(ext_edge_mode[k]),
      .clr      (clr_onehot[2*k]),
      .flag     (flags[2*k])
    );
    irq_sticky_flag u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (tmr_ovf[k]),
      .clr  (clr_onehot[2*k+1]),
      .flag (flags[2*k+1])
    );
  end

  // Serial flag belongs to software: never cleared here.
  assign flags[SRC_SER] = ser_tx_done | ser_rx_done;
  assign pending        = flags & src_en;

  irq_arbiter #(.N(NUM_SRC)) u_arb (
    .pending(pending),
    .any    (any),
    .sel    (sel)
  );

  irq_service_ctl #(.N(NUM_SRC)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .any       (any),
    .sel       (sel),
    .glb_en    (glb_en),
    .ack       (irq_ack),
    .reti      (irq_reti),
    .req       (irq_req),
    .cur       (cur),
    .clr_onehot(clr_onehot)
  );

  assign irq_vec = irq_req ? VEC_W'(VEC_BASE + int'(cur) * VEC_STRIDE) : '0;
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        glb_en,
  input logic        irq_ack,
  input logic        irq_reti,
  input logic        irq_req,
  input logic [15:0] irq_vec
);
  logic in_handler;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   in_handler <= 1'b0;
    else if (irq_req && irq_ack)  in_handler <= 1'b1;
    else if (irq_reti)            in_handler <= 1'b0;
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

  p_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec <= 16'h0023));

  p_idle_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == 16'h0000));

  p_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !glb_en) |=> !irq_req);

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler |-> !irq_req);

  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !irq_req);
endmodule

bind irq_vector_unit irq_vector_unit_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .glb_en  (glb_en),
  .irq_ack (irq_ack),
  .irq_reti(irq_reti),
  .irq_req (irq_req),
  .irq_vec (irq_vec)
);

// File: tb/irq_vector_unit_test.sv
module irq_vector_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_irq_n = 2'b11;
  logic [1:0]  ext_edge_mode = 2'b11;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_tx_done = 1'b0;
  logic        ser_rx_done = 1'b0;
  logic [4:0]  src_en = 5'b11111;
  logic        glb_en = 1'b1;
  logic        irq_ack = 1'b0;
  logic        irq_reti = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_unit uut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .ext_edge_mode(ext_edge_mode),
    .tmr_ovf(tmr_ovf), .ser_tx_done(ser_tx_done), .ser_rx_done(ser_rx_done),
    .src_en(src_en), .glb_en(glb_en), .irq_ack(irq_ack), .irq_reti(irq_reti),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic logic [15:0] slot(input int id);
    return 16'h0003 + 16'(id * 8);
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_out(input logic exp_req, input logic [15:0] exp_vec, input string tag);
    n_run++;
    if (irq_req !== exp_req || irq_vec !== exp_vec) begin
      n_fail++;
      $display("FAIL %s: req=%0b vec=%h expected req=%0b vec=%h", tag, irq_req, irq_vec, exp_req, exp_vec);
    end
  endtask

  task automatic pulse_tmr(input int k);
    tmr_ovf[k] = 1'b1; step(1); tmr_ovf[k] = 1'b0;
  endtask

  task automatic do_ack;
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
  endtask

  task automatic do_reti;
    irq_reti = 1'b1; step(1); irq_reti = 1'b0; step(3);
  endtask

  task automatic t_reset;
    expect_out(1'b0, 16'h0000, "R1 reset state");
  endtask

  task automatic t_order;
    glb_en = 1'b0;
    pulse_tmr(1);
    ext_irq_n[1] = 1'b0; step(2); ext_irq_n[1] = 1'b1;
    ser_rx_done = 1'b1;
    pulse_tmr(0);
    step(6);
    expect_out(1'b0, 16'h0000, "R9 global disable blocks");
    glb_en = 1'b1; step(2);
    expect_out(1'b1, slot(1), "R3 timer0 first");
    do_ack; step(4);
    expect_out(1'b0, 16'h0000, "R10 silent until return");
    do_reti;
    expect_out(1'b1, slot(2), "R3 R4 external1 next");
    do_ack; do_reti;
    expect_out(1'b1, slot(3), "R3 R6 timer1 next");
    do_ack; do_reti;
    expect_out(1'b1, slot(4), "R3 serial last");
    do_ack; do_reti;
    expect_out(1'b1, slot(4), "R7 serial not cleared by ack");
    do_ack; ser_rx_done = 1'b0; do_reti; step(2);
    expect_out(1'b0, 16'h0000, "R6 R4 flags cleared by ack");
  endtask

  task automatic t_edge;
    ext_edge_mode[0] = 1'b1;
    ext_irq_n[0] = 1'b0; step(3); ext_irq_n[0] = 1'b1; step(5);
    expect_out(1'b1, slot(0), "R4 sticky edge flag");
    do_ack; do_reti; step(2);
    expect_out(1'b0, 16'h0000, "R4 edge flag cleared on ack");
  endtask

  task automatic t_level;
    ext_edge_mode[0] = 1'b0;
    ext_irq_n[0] = 1'b0; step(5);
    expect_out(1'b1, slot(0), "R5 level request");
    do_ack; do_reti;
    expect_out(1'b1, slot(0), "R5 level held re-requests");
    do_ack; ext_irq_n[0] = 1'b1; step(4); do_reti; step(2);
    expect_out(1'b0, 16'h0000, "R5 level released");
    ext_edge_mode[0] = 1'b1; step(2);
  endtask

  task automatic t_mask;
    src_en[1] = 1'b0;
    pulse_tmr(0); step(4);
    expect_out(1'b0, 16'h0000, "R8 masked timer0 silent");
    src_en[1] = 1'b1; step(2);
    expect_out(1'b1, slot(1), "R8 flag kept while masked");
    do_ack; do_reti; step(2);
    expect_out(1'b0, 16'h0000, "R6 timer0 cleared");
  endtask

  task automatic t_hold;
    pulse_tmr(1); step(2);
    expect_out(1'b1, slot(3), "R2 timer1 slot");
    pulse_tmr(0); step(3);
    expect_out(1'b1, slot(3), "R11 vector held until ack");
    do_ack; do_reti;
    expect_out(1'b1, slot(1), "R3 timer0 after return");
    do_ack; do_reti; step(2);
    expect_out(1'b0, 16'h0000, "R11 all served");
  endtask

  task automatic t_ser_tx;
    ser_tx_done = 1'b1; step(2);
    expect_out(1'b1, slot(4), "R7 transmit-done requests");
    do_ack; ser_tx_done = 1'b0; do_reti; step(2);
    expect_out(1'b0, 16'h0000, "R7 quiet after software clear");
  endtask

  initial begin
    step(3);
    t_reset;
    rst_n = 1'b1;
    step(2);
    t_reset;
    t_order;
    t_edge;
    t_level;
    t_mask;
    t_hold;
    t_ser_tx;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, req=%0b vec=%h expected completion", irq_req, irq_vec);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule